// File: doc/BRIEF.md
# Bit-Masked GPIO Port

This block is a general-purpose I/O port of sixteen pins (parameter `PIN_W`) with a small synchronous register interface. Each pin can be an input or an output. The output value lives in a data register. Software can load that register whole, or change it one bit at a time through three write-only strobes: set, clear and toggle. A strobe acts only on the bit positions written as 1. The bits written as 0 keep their value, so software can change any group of pins in one write without first reading the register.

The incoming pin levels pass through a two-flop synchronizer. The synchronized levels form the status readback and also drive the interrupt logic. Interrupt enables are changed through two more strobes: one raises enable bits and one lowers them, again only where the written bit is 1. The interrupt request is high while any enabled pin configured as an input sees a high synchronized level.

Register offsets (`reg_addr`, 3 bits): 0 = direction (1 = output), 1 = data (whole value), 2 = set, 3 = clear, 4 = toggle, 5 = interrupt-enable set, 6 = interrupt-enable clear, 7 = status (read only). A read at offset 5 or 6 returns the enable register. A read at 2, 3 or 4 returns the data register. Reads are registered: `rd_data` is valid the cycle after the `rd_en` cycle.

Top module: `gpio_wom_port`

## Requirements
- R1: After reset, direction, data and interrupt enables are all zero, `pad_oe` and `pad_out` are zero, and `irq` is low.
- R2: A write to offset 0 loads direction. `pad_oe` equals direction from the cycle after the write, and a pin with direction 0 never has its `pad_oe` bit set.
- R3: A write to offset 1 loads the whole data register. `pad_out` shows data AND direction from the cycle after the write.
- R4: A write to offset 2 sets to 1 the data bits written as 1 and leaves the other bits unchanged.
- R5: A write to offset 3 clears to 0 the data bits written as 1 and leaves the other bits unchanged.
- R6: A write to offset 4 inverts the data bits written as 1 and leaves the other bits unchanged.
- R7: A write to offset 5 sets the interrupt-enable bits written as 1, and a write to offset 6 clears them. All other enable bits keep their value.
- R8: A read at offset 7 returns the pin levels after a two-flop synchronizer. A change on `pad_in` appears in the status readback no earlier than two clocks later.
- R9: `irq` is a registered OR over the pins that are enabled, configured as inputs and high after synchronization. It rises three clocks after the pin rises.
- R10: A write at a strobe offset with an all-zero value leaves data and enables unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register offset |
| wr_data | input | 16 | Write value |
| rd_data | output | 16 | Registered read value |
| pad_in | input | 16 | Sensed pin levels |
| pad_out | output | 16 | Output drive value |
| pad_oe | output | 16 | Per-pin output enable |
| irq | output | 1 | Interrupt request |

## Verification
The bench writes patterns that mix ones and zeros to each strobe. A design that applied a strobe to the whole word, or that treated zeros as clears, would corrupt the untouched bits. It toggles the same pattern twice to confirm the data returns to its start value. It also writes all-zero strobes, which must change nothing. It samples the status readback and `irq` at the exact cycles the synchronizer allows, so a missing or extra flop shows up. It also drives a high level on an enabled pin that is set as an output, which must not raise an interrupt.

// File: rtl/gpio_wom_pkg.sv
package gpio_wom_pkg;
  typedef enum logic [2:0] {
    OFS_DIR   = 3'd0,
    OFS_DATA  = 3'd1,
    OFS_SET   = 3'd2,
    OFS_CLR   = 3'd3,
    OFS_TGL   = 3'd4,
    OFS_IESET = 3'd5,
    OFS_IECLR = 3'd6,
    OFS_STAT  = 3'd7
  } gpio_ofs_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_bitreg.sv
module gpio_bitreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         set,
  input  logic         clr,
  input  logic         tgl,
  input  logic [W-1:0] val,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (load)     nxt = val;
    else if (set) nxt = q | val;
    else if (clr) nxt = q & ~val;
    else if (tgl) nxt = q ^ val;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] en,
  input  logic [W-1:0] dir,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(lvl & en & ~dir);
  end
endmodule

// File: rtl/gpio_wom_port.sv
module gpio_wom_port
  import gpio_wom_pkg::*;
#(
  parameter int PIN_W = 16,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [PIN_W-1:0]  wr_data,
  output logic [PIN_W-1:0]  rd_data,
  input  logic [PIN_W-1:0]  pad_in,
  output logic [PIN_W-1:0]  pad_out,
  output logic [PIN_W-1:0]  pad_oe,
  output logic              irq
);
  logic [PIN_W-1:0] dir_q, data_q, ien_q, sync_lvl;
  gpio_ofs_e ofs;

  assign ofs = gpio_ofs_e'(reg_addr);

  gpio_bitreg #(.W(PIN_W)) u_dir (
    .clk(clk), .rst(rst),
    .load(wr_en && ofs == OFS_DIR), .set(1'b0), .clr(1'b0), .tgl(1'b0),
    .val(wr_data), .q(dir_q)
  );

  gpio_bitreg #(.W(PIN_W)) u_data (
    .clk(clk), .rst(rst),
    .load(wr_en && ofs == OFS_DATA),
    .set(wr_en && ofs == OFS_SET),
    .clr(wr_en && ofs == OFS_CLR),
    .tgl(wr_en && ofs == OFS_TGL),
    .val(wr_data), .q(data_q)
  );

  gpio_bitreg #(.W(PIN_W)) u_ien (
    .clk(clk), .rst(rst),
    .load(1'b0),
    .set(wr_en && ofs == OFS_IESET),
    .clr(wr_en && ofs == OFS_IECLR),
    .tgl(1'b0),
    .val(wr_data), .q(ien_q)
  );

  gpio_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(sync_lvl)
  );

  gpio_irq #(.W(PIN_W)) u_irq (
    .clk(clk), .rst(rst), .lvl(sync_lvl), .en(ien_q), .dir(dir_q), .irq(irq)
  );

  assign pad_oe  = dir_q;
  assign pad_out = data_q & dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      unique case (ofs)
        OFS_DIR:                   rd_data <= dir_q;
        OFS_DATA, OFS_SET,
        OFS_CLR, OFS_TGL:          rd_data <= data_q;
        OFS_IESET, OFS_IECLR:      rd_data <= ien_q;
        default:                   rd_data <= sync_lvl;
      endcase
    end
  end
endmodule

// File: rtl/gpio_wom_port_chk.sv
module gpio_wom_port_chk #(
  parameter int PIN_W = 16,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [PIN_W-1:0]  wr_data,
  input logic [PIN_W-1:0]  pad_out,
  input logic [PIN_W-1:0]  pad_oe,
  input logic              irq
);
  // R2
  dir_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_addr == 3'd0) |=> pad_oe == $past(wr_data));
  // R2
  oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (pad_out & ~pad_oe) == '0);
  // R4
  set_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_addr == 3'd2 && !$past(rst)) |=> ((pad_out & $past(wr_data & pad_oe)) == $past(wr_data & pad_oe)));
  // R5
  clr_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_addr == 3'd3) |=> ((pad_out & $past(wr_data)) == '0));
  // R10
  zero_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_addr >= 3'd2 && reg_addr <= 3'd4 && wr_data == '0) |=> $stable(pad_out));
  // R1
  irq_reset_chk: assert property (@(posedge clk) $past(rst) |-> !irq);
endmodule

bind gpio_wom_port gpio_wom_port_chk #(.PIN_W(PIN_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .reg_addr(reg_addr), .wr_data(wr_data),
  .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
);

// File: tb/test_gpio_wom_port.sv
module test_gpio_wom_port;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 0, rst = 1, wr_en = 0, rd_en = 0;
  logic [2:0] reg_addr = '0;
  logic [W-1:0] wr_data = '0, pad_in = '0;
  logic [W-1:0] rd_data, pad_out, pad_oe;
  logic irq;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_wom_port i_gpio_wom_port (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .rd_data(rd_data), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [W-1:0] d);
    @(negedge clk); wr_en = 1; reg_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0; wr_data = '0;
  endtask

  task automatic rd(logic [2:0] a, output logic [W-1:0] d);
    @(negedge clk); rd_en = 1; reg_addr = a;
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  task automatic t_reset();
    check("R1 oe", pad_oe, '0);
    check("R1 out", pad_out, '0);
    check("R1 irq", {15'd0, irq}, '0);
  endtask

  task automatic t_dir_data();
    logic [W-1:0] v;
    wr(3'd1, 16'hA5C3);
    check("R2 oe while input", pad_oe, '0);
    check("R3 out gated", pad_out, '0);
    wr(3'd0, 16'hFF0F);
    check("R2 oe", pad_oe, 16'hFF0F);
    check("R3 out", pad_out, 16'hA5C3 & 16'hFF0F);
    wr(3'd0, 16'hFFFF);
    rd(3'd1, v);
    check("R3 readback", v, 16'hA5C3);
  endtask

  task automatic t_strobes();
    logic [W-1:0] v;
    wr(3'd1, 16'h0F0F);
    wr(3'd2, 16'h3030);
    check("R4 set", pad_out, 16'h3F3F);
    wr(3'd3, 16'h0303);
    check("R5 clear", pad_out, 16'h3C3C);
    wr(3'd4, 16'hFF00);
    check("R6 toggle", pad_out, 16'hC33C);
    wr(3'd4, 16'hFF00);
    check("R6 toggle back", pad_out, 16'h3C3C);
    wr(3'd2, '0); wr(3'd3, '0); wr(3'd4, '0);
    check("R10 zero strobes", pad_out, 16'h3C3C);
    rd(3'd2, v);
    check("R10 readback", v, 16'h3C3C);
  endtask

  task automatic t_ien();
    logic [W-1:0] v;
    wr(3'd5, 16'h0011);
    wr(3'd5, 16'h0100);
    rd(3'd5, v);
    check("R7 set enables", v, 16'h0111);
    wr(3'd6, 16'h0010);
    wr(3'd6, '0);
    rd(3'd6, v);
    check("R7 clear enables", v, 16'h0101);
  endtask

  task automatic t_sync_irq();
    logic [W-1:0] v;
    wr(3'd0, 16'h0100);
    @(negedge clk); pad_in = 16'h0001;
    @(negedge clk);
    check("R9 irq not yet", {15'd0, irq}, '0);
    @(negedge clk);
    check("R9 irq at 2", {15'd0, irq}, '0);
    @(negedge clk);
    check("R9 irq at 3", {15'd0, irq}, 16'd1);
    rd(3'd7, v);
    check("R8 status", v, 16'h0001);
    pad_in = 16'h0100;
    repeat (4) @(negedge clk);
    check("R9 output pin no irq", {15'd0, irq}, '0);
    pad_in = 16'h8000;
    @(negedge clk); rd_en = 1; reg_addr = 3'd7;
    @(negedge clk); rd_en = 0;
    check("R8 not before sync", rd_data, 16'h0100);
    rd(3'd7, v);
    check("R8 after sync", v, 16'h8000);
    check("R9 disabled pin", {15'd0, irq}, '0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_dir_data();
        t_strobes();
        t_ien();
        t_sync_irq();
      end
      begin
        repeat (5000) @(negedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule